// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet port. For each incoming frame it takes the 48-bit destination address and decides whether the frame is kept. It also picks the receive queue a kept frame goes to. Address byte 0 is the first byte on the wire and is carried in bits 47:40 of the address input.

Unicast addresses must match a programmed station address in all but their last four bits. Those four bits then select one of sixteen table entries. Multicast addresses in the reserved 01-00-5E-00-00 block are looked up by their last byte in a 256-entry table. All other multicast addresses are hashed to eight bits and looked up in a second 256-entry table. Broadcast is always kept. Each table entry is one byte, holding an accept flag and a queue number.

A word-wide register window writes and reads back the station address and all three tables. A single strobe clears every table in one cycle, which rejects everything except broadcast.

Top module: `rx_da_filter`

## Requirements
- R1: `dec_vld` is high exactly in the cycle after a cycle with `da_vld` high, and low otherwise. `dec_accept` and `dec_queue` are meaningful while `dec_vld` is high.
- R2: A rejected frame reports `dec_accept` 0 and `dec_queue` 0.
- R3: The all-ones address is accepted to queue 0 whatever the tables and station address hold.
- R4: A unicast address (bit 40 clear) is accepted only when its bits 47:4 equal the station address bits 47:4 and the selected unicast entry has its accept bit set. Any mismatch rejects the frame.
- R5: Table entries are bytes with bit 0 the accept flag and bits QW:1 the queue. Unicast entry n lives in register 4 + n/4, in bits 8*(n mod 4)+7 : 8*(n mod 4), and is selected by address bits 3:0.
- R6: Register 0 holds station bytes 0 to 3, with byte 0 in bits 31:24. Register 1 holds bytes 4 and 5 in bits 15:0, with byte 4 in bits 15:8.
- R7: An address with bit 40 set is multicast and never consults the unicast table or the station address.
- R8: Addresses with bits 47:8 equal to 01-00-5E-00-00 use the special table, indexed by bits 7:0. Entry i lives in register 0x40 + i/4, lane i mod 4.
- R9: All other multicast addresses use the other table. Its index is a CRC-8 with polynomial 0x07, initial value 0 and no final inversion, computed over address bits 47 down to 0. Entry i lives in register 0x80 + i/4, lane i mod 4.
- R10: A `tbl_clear` pulse zeroes all three tables at the next edge and leaves the station address unchanged. A table write in the same cycle is discarded.
- R11: `cfg_rdata` shows, in the same cycle, the content of the register at `cfg_addr`. Unmapped addresses (2, 3, 8 to 0x3F, 0xC0 to 0xFF) read 0 and ignore writes.
- R12: After reset the station address and all tables read 0 and `dec_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (8) | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| tbl_clear | input | 1 | Zero all three tables |
| da_vld | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| dec_vld | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_queue | output | QW (3) | Receive queue of an accepted frame |

## Verification
The bench builds the block with its defaults: a 3-bit queue and an 8-bit register address. With these sizes every table is small enough to sweep in full. All sixteen unicast nibbles and all 256 special-multicast indices are looked up one by one against table patterns that alternate the accept bit. A few hundred pseudo-random multicast addresses reach the other table through a CRC computed in the bench. Near-miss addresses probe each edge of the classification: one wrong nibble, the multicast bit flipped on the station address, and a prefix one off the reserved block.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

  localparam int MAC_W    = 48;
  localparam int UC_IDX_W = 4;
  localparam int MC_IDX_W = 8;
  localparam logic [39:0] SPECIAL_PREFIX = 40'h01_00_5E_00_00;

  typedef enum logic [1:0] {
    DA_UNICAST,
    DA_SPECIAL,
    DA_OTHER_MC,
    DA_BROADCAST
  } da_kind_e;

  // Bitwise CRC-8, polynomial 0x07, seed 0, address bit 47 shifted first
  function automatic logic [MC_IDX_W-1:0] hash8(input logic [MAC_W-1:0] a);
    logic [MC_IDX_W-1:0] c;
    logic                fb;
    c = '0;
    for (int i = MAC_W - 1; i >= 0; i--) begin
      fb = c[MC_IDX_W-1] ^ a[i];
      c  = {c[MC_IDX_W-2:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_da_tables.sv
module rx_da_tables
  import rx_da_filter_pkg::*;
#(
  parameter int QW     = 3,
  parameter int CFG_AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  input  logic                tbl_clear,
  output logic [31:0]         cfg_rdata,
  input  logic [UC_IDX_W-1:0] uc_idx,
  input  logic [MC_IDX_W-1:0] sm_idx,
  input  logic [MC_IDX_W-1:0] om_idx,
  output logic [QW:0]         uc_ent,
  output logic [QW:0]         sm_ent,
  output logic [QW:0]         om_ent,
  output logic [MAC_W-1:4]    st_key
);

  localparam int UC_N  = 1 << UC_IDX_W;
  localparam int MC_N  = 1 << MC_IDX_W;
  localparam int MC_AW = MC_IDX_W - 2;
  localparam int RG_W  = CFG_AW - MC_AW;
  localparam int LANES = 4;

  logic [7:0]  uc_q [UC_N];
  logic [7:0]  uc_d [UC_N];
  logic [7:0]  sm_q [MC_N];
  logic [7:0]  sm_d [MC_N];
  logic [7:0]  om_q [MC_N];
  logic [7:0]  om_d [MC_N];
  logic [31:0] sth_q, sth_d;
  logic [15:0] stl_q, stl_d;

  // Address decode: region in the upper bits, word in the lower MC_AW bits
  logic [RG_W-1:0]  region;
  logic [MC_AW-1:0] off;
  logic in_misc, in_sm, in_om, is_sth, is_stl, is_uc;
  logic tbl_en, st_en;

  assign region  = cfg_addr[CFG_AW-1:MC_AW];
  assign off     = cfg_addr[MC_AW-1:0];
  assign in_misc = (region == RG_W'(0));
  assign in_sm   = (region == RG_W'(1));
  assign in_om   = (region == RG_W'(2));
  assign is_sth  = in_misc && (off == MC_AW'(0));
  assign is_stl  = in_misc && (off == MC_AW'(1));
  assign is_uc   = in_misc && (off[MC_AW-1:2] == (MC_AW-2)'(1));

  assign tbl_en  = tbl_clear | (cfg_we & (is_uc | in_sm | in_om));
  assign st_en   = cfg_we & (is_sth | is_stl);

  // Next-state
  always_comb begin
    uc_d  = uc_q;
    sm_d  = sm_q;
    om_d  = om_q;
    sth_d = sth_q;
    stl_d = stl_q;
    if (tbl_clear) begin
      for (int i = 0; i < UC_N; i++) uc_d[i] = '0;
      for (int i = 0; i < MC_N; i++) begin
        sm_d[i] = '0;
        om_d[i] = '0;
      end
    end else if (cfg_we) begin
      for (int k = 0; k < LANES; k++) begin
        if (is_uc) uc_d[{off[1:0], 2'(k)}] = cfg_wdata[8*k +: 8];
        if (in_sm) sm_d[{off, 2'(k)}]      = cfg_wdata[8*k +: 8];
        if (in_om) om_d[{off, 2'(k)}]      = cfg_wdata[8*k +: 8];
      end
    end
    if (cfg_we && is_sth) sth_d = cfg_wdata;
    if (cfg_we && is_stl) stl_d = cfg_wdata[15:0];
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < UC_N; i++) uc_q[i] <= '0;
      for (int i = 0; i < MC_N; i++) begin
        sm_q[i] <= '0;
        om_q[i] <= '0;
      end
      sth_q <= '0;
      stl_q <= '0;
    end else begin
      if (tbl_en) begin
        uc_q <= uc_d;
        sm_q <= sm_d;
        om_q <= om_d;
      end
      if (st_en) begin
        sth_q <= sth_d;
        stl_q <= stl_d;
      end
    end
  end

  // Register read-back
  always_comb begin
    cfg_rdata = '0;
    if (is_sth) begin
      cfg_rdata = sth_q;
    end else if (is_stl) begin
      cfg_rdata = {16'h0000, stl_q};
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (is_uc) cfg_rdata[8*k +: 8] = uc_q[{off[1:0], 2'(k)}];
        if (in_sm) cfg_rdata[8*k +: 8] = sm_q[{off, 2'(k)}];
        if (in_om) cfg_rdata[8*k +: 8] = om_q[{off, 2'(k)}];
      end
    end
  end

  // Lookup ports: accept flag plus queue field only
  assign uc_ent = uc_q[uc_idx][QW:0];
  assign sm_ent = sm_q[sm_idx][QW:0];
  assign om_ent = om_q[om_idx][QW:0];
  assign st_key = {sth_q, stl_q[15:4]};

endmodule

// File: rtl/rx_da_classify.sv
module rx_da_classify
  import rx_da_filter_pkg::*;
(
  input  logic [MAC_W-1:0]    da,
  input  logic [MAC_W-1:4]    st_key,
  output da_kind_e            kind,
  output logic                uc_match,
  output logic [UC_IDX_W-1:0] uc_idx,
  output logic [MC_IDX_W-1:0] sm_idx,
  output logic [MC_IDX_W-1:0] om_idx
);

  assign uc_idx   = da[UC_IDX_W-1:0];
  assign sm_idx   = da[MC_IDX_W-1:0];
  assign om_idx   = hash8(da);
  assign uc_match = (da[MAC_W-1:4] == st_key);

  // Broadcast outranks the multicast checks; the group bit is bit 40
  always_comb begin
    if (&da)
      kind = DA_BROADCAST;
    else if (da[MAC_W-1:8] == SPECIAL_PREFIX)
      kind = DA_SPECIAL;
    else if (da[40])
      kind = DA_OTHER_MC;
    else
      kind = DA_UNICAST;
  end

endmodule

// File: rtl/rx_da_decide.sv
module rx_da_decide
  import rx_da_filter_pkg::*;
#(
  parameter int QW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          da_vld,
  input  da_kind_e      kind,
  input  logic          uc_match,
  input  logic [QW:0]   uc_ent,
  input  logic [QW:0]   sm_ent,
  input  logic [QW:0]   om_ent,
  output logic          dec_vld,
  output logic          dec_accept,
  output logic [QW-1:0] dec_queue
);

  logic [QW:0]   sel;
  logic          acc_d, acc_q, vld_q;
  logic [QW-1:0] q_d, q_q;

  always_comb begin
    unique case (kind)
      DA_BROADCAST: sel = {{QW{1'b0}}, 1'b1};
      DA_SPECIAL:   sel = sm_ent;
      DA_OTHER_MC:  sel = om_ent;
      default:      sel = uc_match ? uc_ent : '0;
    endcase
    acc_d = sel[0];
    q_d   = sel[0] ? sel[QW:1] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      q_q   <= '0;
    end else begin
      vld_q <= da_vld;
      if (da_vld) begin
        acc_q <= acc_d;
        q_q   <= q_d;
      end
    end
  end

  assign dec_vld    = vld_q;
  assign dec_accept = acc_q;
  assign dec_queue  = q_q;

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
#(
  parameter int QW     = 3,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              tbl_clear,
  input  logic              da_vld,
  input  logic [47:0]       da,
  output logic              dec_vld,
  output logic              dec_accept,
  output logic [QW-1:0]     dec_queue
);

  logic [UC_IDX_W-1:0] uc_idx;
  logic [MC_IDX_W-1:0] sm_idx, om_idx;
  logic [QW:0]         uc_ent, sm_ent, om_ent;
  logic [MAC_W-1:4]    st_key;
  logic                uc_match;
  da_kind_e            kind;

  rx_da_tables #(.QW(QW), .CFG_AW(CFG_AW)) u_tables (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .tbl_clear (tbl_clear),
    .cfg_rdata (cfg_rdata),
    .uc_idx    (uc_idx),
    .sm_idx    (sm_idx),
    .om_idx    (om_idx),
    .uc_ent    (uc_ent),
    .sm_ent    (sm_ent),
    .om_ent    (om_ent),
    .st_key    (st_key)
  );

  rx_da_classify u_classify (
    .da       (da),
    .st_key   (st_key),
    .kind     (kind),
    .uc_match (uc_match),
    .uc_idx   (uc_idx),
    .sm_idx   (sm_idx),
    .om_idx   (om_idx)
  );

  rx_da_decide #(.QW(QW)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .da_vld     (da_vld),
    .kind       (kind),
    .uc_match   (uc_match),
    .uc_ent     (uc_ent),
    .sm_ent     (sm_ent),
    .om_ent     (om_ent),
    .dec_vld    (dec_vld),
    .dec_accept (dec_accept),
    .dec_queue  (dec_queue)
  );

endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk #(
  parameter int QW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tbl_clear,
  input logic          da_vld,
  input logic [47:0]   da,
  input logic          dec_vld,
  input logic          dec_accept,
  input logic [QW-1:0] dec_queue
);

  AST_DEC_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    da_vld |=> dec_vld); // R1
  AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    !da_vld |=> !dec_vld); // R1
  AST_REJECT_QUEUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !dec_accept) |-> (dec_queue == '0)); // R2
  AST_BCAST_TO_QUEUE0: assert property (@(posedge clk) disable iff (!rst_n)
    (da_vld && (&da)) |=> (dec_accept && dec_queue == '0)); // R3
  AST_CLEARED_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (da_vld && !(&da) && $past(tbl_clear)) |=> !dec_accept); // R10

endmodule

bind rx_da_filter rx_da_filter_chk #(.QW(QW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tbl_clear  (tbl_clear),
  .da_vld     (da_vld),
  .da         (da),
  .dec_vld    (dec_vld),
  .dec_accept (dec_accept),
  .dec_queue  (dec_queue)
);

// File: tb/rx_da_filter_test.sv
`timescale 1ns/1ps
module rx_da_filter_test;

  localparam int QW = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        tbl_clear;
  logic        da_vld;
  logic [47:0] da;
  logic        dec_vld, dec_accept;
  logic [QW-1:0] dec_queue;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  m_uc [16];
  logic [7:0]  m_sm [256];
  logic [7:0]  m_om [256];
  logic [31:0] st_hi;
  logic [15:0] st_lo;

  always #2 clk = ~clk;

  rx_da_filter #(.QW(QW), .CFG_AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tbl_clear(tbl_clear),
    .da_vld(da_vld), .da(da), .dec_vld(dec_vld), .dec_accept(dec_accept),
    .dec_queue(dec_queue)
  );

  function automatic logic [7:0] ref_crc(input logic [47:0] a);
    logic [7:0] c = 8'h00;
    for (int i = 47; i >= 0; i--) begin
      if (c[7] ^ a[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [7:0] exp_ent(input logic [47:0] a);
    if (&a)                          return 8'h01;
    if (a[47:8] == 40'h01005E0000)   return m_sm[a[7:0]];
    if (a[40])                       return m_om[ref_crc(a)];
    if (a[47:4] == {st_hi, st_lo[15:4]}) return m_uc[a[3:0]];
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(cfg_rdata == e, tag, 64'(cfg_rdata), 64'(e));
  endtask

  task automatic look(input logic [47:0] a, input string tag);
    logic [7:0] e;
    logic       ea;
    logic [2:0] eq;
    e  = exp_ent(a);
    ea = e[0];
    eq = ea ? e[3:1] : 3'd0;
    @(negedge clk);
    da_vld = 1'b1; da = a;
    @(negedge clk);
    da_vld = 1'b0;
    check(dec_vld && dec_accept == ea && dec_queue == eq, tag,
          64'({dec_vld, dec_accept, dec_queue}), 64'({1'b1, ea, eq}));
  endtask

  function automatic logic [31:0] pack4(input logic [7:0] b0, input logic [7:0] b1,
                                        input logic [7:0] b2, input logic [7:0] b3);
    return {b3, b2, b1, b0};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] lcg;
    logic [47:0] a;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tbl_clear = 1'b0; da_vld = 1'b0; da = '0;
    for (int i = 0; i < 16; i++)  m_uc[i] = 8'h00;
    for (int i = 0; i < 256; i++) begin m_sm[i] = 8'h00; m_om[i] = 8'h00; end
    st_hi = '0; st_lo = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    check(dec_vld == 1'b0, "R12 dec_vld", 64'(dec_vld), 64'(0));
    rd_chk(8'h00, 32'h0, "R12 station hi");
    rd_chk(8'h05, 32'h0, "R12 unicast reg");
    rd_chk(8'h40, 32'h0, "R12 special reg");
    rd_chk(8'hBF, 32'h0, "R12 other reg");

    // R6: station address layout
    st_hi = 32'h0211_2233; st_lo = 16'h4459;
    wr(8'h00, st_hi);
    wr(8'h01, {16'hABCD, st_lo});
    rd_chk(8'h00, st_hi, "R6 station hi");
    rd_chk(8'h01, {16'h0, st_lo}, "R6 station lo");

    // R5: unicast table packing
    for (int i = 0; i < 16; i++) m_uc[i] = 8'((i * 53 + 7) & 255);
    for (int w = 0; w < 4; w++)
      wr(8'(4 + w), pack4(m_uc[4*w], m_uc[4*w+1], m_uc[4*w+2], m_uc[4*w+3]));
    for (int w = 0; w < 4; w++)
      rd_chk(8'(4 + w), pack4(m_uc[4*w], m_uc[4*w+1], m_uc[4*w+2], m_uc[4*w+3]), "R5 readback");

    // R8, R9: fill both multicast tables
    for (int i = 0; i < 256; i++) begin
      m_sm[i] = 8'((i * 73 + 11) & 255);
      m_om[i] = 8'((i * 29 + 4) & 255);
    end
    for (int w = 0; w < 64; w++) begin
      wr(8'(8'h40 + w), pack4(m_sm[4*w], m_sm[4*w+1], m_sm[4*w+2], m_sm[4*w+3]));
      wr(8'(8'h80 + w), pack4(m_om[4*w], m_om[4*w+1], m_om[4*w+2], m_om[4*w+3]));
    end
    rd_chk(8'h57, pack4(m_sm[92], m_sm[93], m_sm[94], m_sm[95]), "R8 readback");
    rd_chk(8'hA3, pack4(m_om[140], m_om[141], m_om[142], m_om[143]), "R9 readback");

    // R4, R5, R2: every unicast nibble on the station prefix
    for (int n = 0; n < 16; n++) look({st_hi, st_lo[15:4], 4'(n)}, "R4 R5 unicast sweep");
    // R4: near misses
    look({st_hi, st_lo[15:8], 4'h6, 4'h1}, "R4 high nibble mismatch");
    look({st_hi ^ 32'h0200_0000, st_lo[15:4], 4'h1}, "R4 byte0 mismatch");
    look({st_hi, st_lo ^ 16'h0100}, "R4 byte4 mismatch");

    // R1: no decision without a strobe
    @(negedge clk);
    check(dec_vld == 1'b0, "R1 idle", 64'(dec_vld), 64'(0));

    // R8: special multicast full sweep
    for (int i = 0; i < 256; i++) look({40'h01005E0000, 8'(i)}, "R8 special sweep");
    look({40'h01005E0001, 8'h22}, "R8 prefix one off");

    // R7: station address with group bit set goes to other table
    look({st_hi | 32'h0100_0000, st_lo}, "R7 group bit on station");

    // R9: pseudo-random other multicast
    lcg = 64'h1234_5678_9ABC_DEF0;
    for (int i = 0; i < 300; i++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      a = lcg[63:16];
      a[40] = 1'b1;
      look(a, "R9 other multicast");
    end

    // R3: broadcast
    look(48'hFFFF_FFFF_FFFF, "R3 broadcast");

    // R11: unmapped addresses
    wr(8'h02, 32'hDEAD_BEEF);
    rd_chk(8'h02, 32'h0, "R11 unmapped low");
    wr(8'hC5, 32'hCAFE_F00D);
    rd_chk(8'hC5, 32'h0, "R11 unmapped high");
    rd_chk(8'h00, st_hi, "R11 station untouched");

    // R10: clear beats a simultaneous write, station kept
    @(negedge clk);
    tbl_clear = 1'b1; cfg_we = 1'b1; cfg_addr = 8'h41; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    tbl_clear = 1'b0; cfg_we = 1'b0;
    for (int i = 0; i < 16; i++)  m_uc[i] = 8'h00;
    for (int i = 0; i < 256; i++) begin m_sm[i] = 8'h00; m_om[i] = 8'h00; end
    rd_chk(8'h41, 32'h0, "R10 write during clear");
    rd_chk(8'h05, 32'h0, "R10 unicast cleared");
    rd_chk(8'h80, 32'h0, "R10 other cleared");
    rd_chk(8'h00, st_hi, "R10 station hi kept");
    rd_chk(8'h01, {16'h0, st_lo}, "R10 station lo kept");
    for (int n = 0; n < 16; n++) look({st_hi, st_lo[15:4], 4'(n)}, "R10 unicast rejected");
    look({40'h01005E0000, 8'h05}, "R10 special rejected");
    look(48'hFFFF_FFFF_FFFF, "R3 broadcast after clear");

    finish_run();
  end

endmodule